// File: doc/BRIEF.md
# Sub-Second Periodic Tick Interrupt

This block raises a periodic interrupt at a fraction of a second. It keeps a free-running 15-bit counter that advances once for each qualified tick of a 32.768 kHz timebase. The counter wraps at 32768 ticks, which marks each whole second. A 3-bit period code picks one tap of that counter. The interval between interrupts is 16 ticks for code 0 and doubles with each step of the code, reaching 2048 ticks for code 7. At 32.768 kHz that spans roughly 0.49 ms to 62.5 ms.

Software writes one 8-bit control byte. The code sits in its low three bits and an interrupt enable sits in its top bit. The four bits between them are not stored. The interrupt is a sticky flag. It stays set until software pulses the clear input, and a new period event in the same cycle wins over that clear.

Top module: `subsec_tick_irq`

## Requirements
- R1: After reset, `irq` is 0, `ctl_rdata` reads 8'h00 (code 0, interrupt disabled) and the tick counter starts from 0.
- R2: With the enable set and period code k in `ctl_rdata[2:0]`, an event occurs on each tick that carries the counter to a multiple of 16·2^k. From reset that is the 16·2^k-th tick, and `irq` reads 1 from the cycle after that tick.
- R3: The counter advances only in cycles where `tick_en` is 1. Cycles without `tick_en` never produce an event, however long the gaps between ticks.
- R4: While the enable bit (bit 7) is 0, `irq` is never set, though the counter keeps advancing.
- R5: A write with `ctl_we` stores `ctl_wdata[2:0]` as the period code and `ctl_wdata[7]` as the enable. `ctl_rdata` shows the stored code in bits 2:0 and the enable in bit 7 from the cycle after the write. An event in the same cycle as a write uses the settings held before that write.
- R6: Bits 6:3 of a write are discarded, and `ctl_rdata[6:3]` always reads 0.
- R7: Once set, `irq` stays 1 until a cycle with `irq_clr` high and no new event. It reads 0 in the cycle after that.
- R8: When an event and `irq_clr` fall in the same cycle, `irq` stays 1.
- R9: A change of period code takes effect at the next boundary of the new period, counted from the shared counter. The change itself produces no event.
- R10: The counter wraps from 32767 to 0. The wrap is a boundary for every code, so an enabled interrupt fires on the wrapping tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per timebase tick; advances the counter |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control write data: [2:0] period code, [7] enable |
| ctl_rdata | output | 8 | Control read data: [2:0] code, [6:3] zero, [7] enable |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| irq | output | 1 | Sticky sub-second interrupt flag |

## Verification
The counter and the stored settings cannot be read directly, so a fault inside the block shows up only as an event that is early, late, missing or extra. A wrong count value or a wrong tap selection moves the next rising edge of `irq` by up to one full period. For code 7 that can mean 2048 ticks before any difference appears. For this reason the bench compares `irq` every cycle against an arithmetic model, and it runs each code for at least two whole periods. A stuck or lost control bit appears at `ctl_rdata` in the cycle after the write.

// File: rtl/subsec_pkg.sv
package subsec_pkg;

  // log2 of the interrupt period for a given select code
  function automatic int unsigned tap_log2(input int unsigned base_log2,
                                           input int unsigned code);
    return base_log2 + code;
  endfunction

  // all-ones mask of the given number of low bits (32-bit result)
  function automatic logic [31:0] low_mask(input int unsigned nbits);
    if (nbits >= 32) return '1;
    return (32'd1 << nbits) - 32'd1;
  endfunction

endpackage

// File: rtl/subsec_tick_counter.sv
module subsec_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + CNT_W'(1);
  end

  // the tick that carries the counter from all-ones back to zero
  assign wrap_o = tick_en && (&cnt_q);

endmodule

// File: rtl/subsec_ctl_reg.sv
module subsec_ctl_reg #(
  parameter int SEL_W  = 3,
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic             en_q,
  output logic [CTL_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (we) begin
      sel_q <= wdata[SEL_W-1:0];
      en_q  <= wdata[EN_BIT];
    end
  end

  // reserved positions are not stored and read as zero
  always_comb begin
    rdata              = '0;
    rdata[SEL_W-1:0]   = sel_q;
    rdata[EN_BIT]      = en_q;
  end

endmodule

// File: rtl/subsec_event_sel.sv
module subsec_event_sel
  import subsec_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 4
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick_en,
  input  logic             en,
  output logic [CNT_W-1:0] mask,
  output logic             boundary,
  output logic             evt
);

  localparam int NCODE = 1 << SEL_W;

  logic [CNT_W-1:0] mask_tab [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tap
    localparam int unsigned LG = tap_log2(BASE_LOG2, g);
    assign mask_tab[g] = CNT_W'(low_mask(LG));
  end

  assign mask = mask_tab[sel];

  // low bits all ones: this tick brings them back to zero
  assign boundary = tick_en && ((cnt & mask) == mask);
  assign evt      = boundary && en;

endmodule

// File: rtl/subsec_irq_flag.sv
module subsec_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;   // new event beats the clear
    else if (clr_i)  flag_q <= 1'b0;
  end

endmodule

// File: rtl/subsec_tick_irq.sv
module subsec_tick_irq #(
  parameter int CNT_W     = 15,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 4,
  parameter int CTL_W     = 8,
  parameter int EN_BIT    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             irq_clr,
  output logic             irq
);

  localparam int MAX_LOG2 = BASE_LOG2 + (1 << SEL_W) - 1;

  initial begin
    if (MAX_LOG2 > CNT_W) $error("longest period exceeds counter width");
    if (EN_BIT < SEL_W || EN_BIT >= CTL_W) $error("enable bit position invalid");
  end

  logic [CNT_W-1:0] cnt_q;
  logic             sec_wrap;
  logic [SEL_W-1:0] sel_q;
  logic             en_q;
  logic [CNT_W-1:0] tap_mask;
  logic             tap_boundary;
  logic             evt;

  subsec_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cnt_q   (cnt_q),
    .wrap_o  (sec_wrap)
  );

  subsec_ctl_reg #(.SEL_W(SEL_W), .CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .sel_q (sel_q),
    .en_q  (en_q),
    .rdata (ctl_rdata)
  );

  subsec_event_sel #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_evt (
    .cnt      (cnt_q),
    .sel      (sel_q),
    .tick_en  (tick_en),
    .en       (en_q),
    .mask     (tap_mask),
    .boundary (tap_boundary),
    .evt      (evt)
  );

  subsec_irq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt),
    .clr_i  (irq_clr),
    .flag_q (irq)
  );

endmodule

// File: rtl/subsec_tick_irq_chk.sv
module subsec_tick_irq_chk #(
  parameter int CNT_W  = 15,
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             irq_clr,
  input logic             irq,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] tap_mask,
  input logic             en_q,
  input logic             evt,
  input logic             sec_wrap,
  input logic             tap_boundary
);

  // R4
  rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(en_q) && $past(tick_en)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));

  // R2
  evt_lands_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> ((cnt_q & $past(tap_mask)) == '0));

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> irq);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !evt) |=> !irq);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[EN_BIT-1:3] == '0);

  // R10
  wrap_is_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |-> tap_boundary);

endmodule

bind subsec_tick_irq subsec_tick_irq_chk #(.CNT_W(CNT_W), .CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_en      (tick_en),
  .irq_clr      (irq_clr),
  .irq          (irq),
  .ctl_rdata    (ctl_rdata),
  .cnt_q        (cnt_q),
  .tap_mask     (tap_mask),
  .en_q         (en_q),
  .evt          (evt),
  .sec_wrap     (sec_wrap),
  .tap_boundary (tap_boundary)
);

// File: tb/subsec_tick_irq_bench.sv
module subsec_tick_irq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       irq_clr = 1'b0;
  logic       irq;

  always #10 clk = ~clk;   // 50 MHz

  subsec_tick_irq u_subsec_tick_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .irq_clr   (irq_clr),
    .irq       (irq)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  // reference model state
  int       m_cnt = 0;
  bit [2:0] m_sel = 3'd0;
  bit       m_en  = 1'b0;
  bit       m_irq = 1'b0;

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit te, input bit we, input logic [7:0] wd, input bit clr);
    int  period;
    bit  ev;
    tick_en   = te;
    ctl_we    = we;
    ctl_wdata = wd;
    irq_clr   = clr;
    @(posedge clk);
    period = 16 << m_sel;
    ev     = te && m_en && (((m_cnt + 1) % period) == 0);
    if (ev)       m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
    if (te) m_cnt = (m_cnt + 1) % 32768;
    if (we) begin
      m_sel = wd[2:0];
      m_en  = wd[7];
    end
    @(negedge clk);
    check(cur_req, "irq", int'(irq), int'(m_irq));
    check("R5", "ctl_rdata", int'(ctl_rdata), int'({m_en, 4'b0000, m_sel}));
    tick_en = 1'b0;
    ctl_we  = 1'b0;
    irq_clr = 1'b0;
  endtask

  // ticks every cycle, clearing the flag whenever it is seen set
  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, irq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "irq after reset", int'(irq), 0);
    check("R1", "ctl_rdata after reset", int'(ctl_rdata), 0);

    // R6 reserved bits dropped on write
    cur_req = "R6";
    step(1'b0, 1'b1, 8'hFF, 1'b0);
    check("R6", "rdata after 0xFF", int'(ctl_rdata), 8'h87);
    step(1'b0, 1'b1, 8'h78, 1'b0);
    check("R6", "rdata after 0x78", int'(ctl_rdata), 8'h00);

    // R4 disabled: counter advances, no flag
    cur_req = "R4";
    step(1'b0, 1'b1, 8'h00, 1'b0);
    run_ticks(100);
    check("R4", "irq while disabled", int'(irq), 0);

    // R2 sweep every code over at least two periods
    for (int k = 0; k < 8; k++) begin
      cur_req = "R2";
      step(1'b0, 1'b1, 8'(8'h80 | k), 1'b0);
      run_ticks((16 << k) * 2 + 3);
    end

    // R3 gapped ticks: one tick every third cycle, code 2
    cur_req = "R3";
    step(1'b0, 1'b1, 8'h82, 1'b0);
    for (int i = 0; i < 200; i++) begin
      step(1'b1, 1'b0, 8'h00, irq);
      step(1'b0, 1'b0, 8'h00, 1'b0);
      step(1'b0, 1'b0, 8'h00, 1'b0);
    end

    // R7 flag holds without a clear, drops after one
    cur_req = "R7";
    step(1'b0, 1'b1, 8'h80, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 8'h00, 1'b0);
    check("R7", "irq held", int'(irq), 1);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    check("R7", "irq after clear", int'(irq), 0);

    // R8 clear held every cycle: events still set the flag
    cur_req = "R8";
    for (int i = 0; i < 64; i++) step(1'b1, 1'b0, 8'h00, 1'b1);

    // R9 change from code 7 to code 0 mid-period, then back up
    cur_req = "R9";
    step(1'b0, 1'b1, 8'h87, 1'b0);
    run_ticks(37);
    step(1'b1, 1'b1, 8'h80, irq);
    run_ticks(50);
    step(1'b1, 1'b1, 8'h85, irq);
    run_ticks(700);

    // R5 write coinciding with event uses old settings
    cur_req = "R5";
    step(1'b0, 1'b1, 8'h80, irq);
    while (((m_cnt + 1) % 16) != 0) step(1'b1, 1'b0, 8'h00, irq);
    step(1'b1, 1'b1, 8'h00, 1'b0);
    check("R5", "event with disabling write", int'(irq), 1);

    // R10 wrap of the counter with the longest code
    cur_req = "R10";
    step(1'b0, 1'b1, 8'h87, 1'b1);
    run_ticks(32768 - m_cnt + 20);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule